// File: doc/BRIEF.md
# Infrared Remote Serial Receiver with Group-Threshold FIFO

This block receives asynchronous serial characters from an infrared remote-control front end and queues them for a host processor. A programmable divisor sets a 16x oversampling tick, from which each character (one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit) is recovered. Each received character is stored in a 16-entry receive queue as one byte: the low six data bits, plus a parity-error flag and a framing-error flag in the two upper bits.

The host sees four registers on a small word-addressed bus: control (parity mode, interrupt enable, queue flush), configuration (divisor and group count), status (data-available and queue-full), and receive data (reading pops one entry). Data-available rises only once the queue holds a whole group of bytes, so a host that reads a multi-byte remote code in one burst is woken only when the code is complete. The interrupt output is a level signal.

Top module: `irrx_uart`

## Requirements
- R1: After reset every register reads 0 (divisor 0, group count 0, parity none, interrupt disabled), status reads 0 and `irq` is low.
- R2: With divisor D in configuration bits [7:0], the oversampling tick period is D clock cycles (one cycle for D of 0 or 1) and a bit lasts 16 ticks; a character sent at that rate is stored with data bits [5:0] in entry bits [5:0], bits [7:6] of the data being discarded.
- R3: Control bits [1:0] select parity: 1 odd, 2 even, 0 or 3 none (no parity bit in the frame). Entry bit 6 is set when the received parity bit disagrees with the selected mode and is never set with parity off.
- R4: Entry bit 7 is set when the stop bit samples low; after such a frame the receiver waits for the line to return high before accepting a new start bit.
- R5: Status bit 0 (data-available) is 1 exactly when the queue holds at least G+1 entries, G being configuration bits [15:8].
- R6: `irq` equals status bit 0 while control bit 4 is 1, and is 0 while control bit 4 is 0.
- R7: Writing control with bit 5 set empties the queue at once; bit 5 always reads 0.
- R8: The queue holds 16 entries; status bit 1 reports it full, and a character arriving while full is dropped without disturbing stored entries.
- R9: Reading the receive data register (address 3) returns the oldest entry and removes it; reading it while empty returns 0 and leaves the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register index: 0 control, 1 configuration, 2 status, 3 receive data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| rx_in | input | 1 | Serial line from the infrared receiver, idle high |
| irq | output | 1 | Level interrupt: data-available gated by enable |

## Verification
The bench aims at the group threshold, sending exactly G+1 characters and checking that data-available is still low one character short; an off-by-one compare would raise it early or one byte late. It fills the queue and sends one more character, where a design that overwrote on full would corrupt the oldest entry or return seventeen bytes, and it reads an empty queue, where a pointer underflow would later return stale bytes. Random runs mix parity modes, bad parity bits and low stop bits, so a design that inverted odd and even, flagged parity with parity off, or retriggered on the low stop level would show wrong error bits or phantom entries.

// File: rtl/irrx_pkg.sv
// Shared constants and types for the infrared serial receiver.
// Assumes: register indices and field positions below are the host-visible map.
package irrx_pkg;
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_CFG  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_DATA = 2'd3;

    localparam int CTRL_IE_BIT    = 4;
    localparam int CTRL_FLUSH_BIT = 5;
    localparam int STAT_AVAIL_BIT = 0;
    localparam int STAT_FULL_BIT  = 1;

    localparam logic [1:0] PAR_ODD  = 2'd1;
    localparam logic [1:0] PAR_EVEN = 2'd2;

    localparam int OVS       = 16;
    localparam int DATA_BITS = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    // True when the parity mode inserts a parity bit into the frame.
    function automatic logic parity_on(input logic [1:0] mode);
        return (mode == PAR_ODD) || (mode == PAR_EVEN);
    endfunction
endpackage

// File: rtl/irrx_baud_tick.sv
// Oversampling tick generator.
// Emits a one-cycle tick every DIV clock cycles; DIV of 0 or 1 ticks each cycle.
// Assumes: divisor may change at any time; the counter wraps safely if it shrinks.
module irrx_baud_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             fast;

    assign fast = (div <= DIV_W'(1));
    assign tick = fast || (cnt >= div - DIV_W'(1));

    // Count clock cycles between ticks, restarting on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end

    // R2: with a divisor above one, two ticks are never adjacent.
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !fast) |=> (div <= DIV_W'(1) || !tick));
endmodule

// File: rtl/irrx_frame_rx.sv
// Serial frame receiver: start, 8 data bits LSB first, optional parity, stop.
// Produces one push per frame with {framing_err, parity_err, data[5:0]}.
// Assumes: rx is already synchronised; tick is the 16x oversampling strobe.
module irrx_frame_rx
    import irrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] par_mode,
    output logic       push,
    output logic [7:0] push_byte
);
    localparam int SC_W = $clog2(OVS);
    localparam logic [SC_W-1:0] START_LAST = SC_W'(OVS / 2 - 1);
    localparam logic [SC_W-1:0] BIT_LAST   = SC_W'(OVS - 1);
    localparam int BN_W = $clog2(DATA_BITS);

    rx_state_t             state;
    logic [SC_W-1:0]       sc;
    logic [BN_W-1:0]       bitn;
    logic [DATA_BITS-1:0]  shreg;
    logic                  par_bit;
    logic                  line_hi;
    logic                  par_en;
    logic                  par_bad;
    logic                  at_end;

    assign par_en  = parity_on(par_mode);
    assign at_end  = (sc == BIT_LAST);
    assign par_bad = par_en &&
                     ((par_mode == PAR_ODD) ? !(^{shreg, par_bit}) : (^{shreg, par_bit}));
    assign push      = tick && (state == RX_STOP) && at_end;
    assign push_byte = {!rx, par_bad, shreg[5:0]};

    // Frame sequencer: advances on oversampling ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            sc      <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            line_hi <= 1'b0;
        end else if (tick) begin
            unique case (state)
                RX_IDLE: begin
                    line_hi <= rx;
                    sc      <= '0;
                    if (line_hi && !rx) state <= RX_START;
                end
                RX_START: begin
                    if (sc == START_LAST) begin
                        sc   <= '0;
                        bitn <= '0;
                        if (!rx) state <= RX_DATA;
                        else begin
                            state   <= RX_IDLE;
                            line_hi <= 1'b1;
                        end
                    end else sc <= sc + SC_W'(1);
                end
                RX_DATA: begin
                    if (at_end) begin
                        sc    <= '0;
                        shreg <= {rx, shreg[DATA_BITS-1:1]};
                        bitn  <= bitn + BN_W'(1);
                        if (bitn == BN_W'(DATA_BITS - 1))
                            state <= par_en ? RX_PAR : RX_STOP;
                    end else sc <= sc + SC_W'(1);
                end
                RX_PAR: begin
                    if (at_end) begin
                        sc      <= '0;
                        par_bit <= rx;
                        state   <= RX_STOP;
                    end else sc <= sc + SC_W'(1);
                end
                RX_STOP: begin
                    if (at_end) begin
                        sc      <= '0;
                        line_hi <= rx;
                        state   <= RX_IDLE;
                    end else sc <= sc + SC_W'(1);
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R3: with parity off, no stored byte ever carries a parity error.
    a_r3_no_perr_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !parity_on(par_mode)) |-> !push_byte[6]);

    // R2: every data phase begins at bit zero.
    a_r2_data_starts_at_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_DATA && $past(state) == RX_START) |-> (bitn == '0));

    // R4: a frame with a low stop bit blocks a new start until the line is seen high.
    a_r4_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_byte[7]) |=> !line_hi);
endmodule

// File: rtl/irrx_fifo.sv
// Receive queue: DEPTH entries of WIDTH bits, first in first out.
// Pushes while full are dropped; pops while empty are ignored; flush empties it.
// Assumes: dout is only meaningful while empty is low.
module irrx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] dout,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    // Advance a pointer with explicit wrap so any depth works.
    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Store incoming entries.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Track pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            if (do_push && !do_pop)      level <= level + LVL_W'(1);
            else if (do_pop && !do_push) level <= level - LVL_W'(1);
        end
    end

    // R8: occupancy never exceeds the depth.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R8: a push into a full queue with no pop leaves it full.
    a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);

    // R9: popping an empty queue leaves it empty.
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

    // R7: flush leaves the queue empty on the next cycle.
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/irrx_uart.sv
// Infrared serial receiver top: register bus, line synchroniser, tick
// generator, frame receiver and group-threshold receive queue.
// Assumes: one-cycle bus strobes; reads of the data register pop on the strobe edge.
module irrx_uart
    import irrx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 8,
    parameter int GRP_W      = 8,
    parameter int BUS_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             rx_in,
    output logic             irq
);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
    localparam int CMP_W = ((GRP_W > LVL_W) ? GRP_W : LVL_W) + 1;

    logic [1:0]       par_mode;
    logic             irq_en;
    logic [DIV_W-1:0] divisor;
    logic [GRP_W-1:0] group;
    logic [1:0]       rx_sync;
    logic             tick;
    logic             push;
    logic [7:0]       push_byte;
    logic             pop;
    logic             flush;
    logic [7:0]       fifo_dout;
    logic [LVL_W-1:0] level;
    logic             fifo_full;
    logic             fifo_empty;
    logic             avail;
    logic             wr_ctrl;
    logic             wr_cfg;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == REG_CTRL);
    assign wr_cfg  = bus_sel && bus_wr && (bus_addr == REG_CFG);
    assign flush   = wr_ctrl && bus_wdata[CTRL_FLUSH_BIT];
    assign pop     = bus_sel && !bus_wr && (bus_addr == REG_DATA);
    assign avail   = CMP_W'(level) > CMP_W'(group);
    assign irq     = avail && irq_en;

    // Control register: parity mode and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_mode <= '0;
            irq_en   <= 1'b0;
        end else if (wr_ctrl) begin
            par_mode <= bus_wdata[1:0];
            irq_en   <= bus_wdata[CTRL_IE_BIT];
        end
    end

    // Configuration register: divisor and group count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor <= '0;
            group   <= '0;
        end else if (wr_cfg) begin
            divisor <= bus_wdata[DIV_W-1:0];
            group   <= bus_wdata[DIV_W +: GRP_W];
        end
    end

    // Two-stage synchroniser for the asynchronous serial line.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rx_in};
    end

    irrx_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (divisor),
        .tick (tick)
    );

    irrx_frame_rx u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rx       (rx_sync[1]),
        .par_mode (par_mode),
        .push     (push),
        .push_byte(push_byte)
    );

    irrx_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .din  (push_byte),
        .pop  (pop),
        .flush(flush),
        .dout (fifo_dout),
        .level(level),
        .full (fifo_full),
        .empty(fifo_empty)
    );

    // Read multiplexer for the addressed register.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                bus_rdata[1:0]         = par_mode;
                bus_rdata[CTRL_IE_BIT] = irq_en;
            end
            REG_CFG: begin
                bus_rdata[DIV_W-1:0]     = divisor;
                bus_rdata[DIV_W +: GRP_W] = group;
            end
            REG_STAT: begin
                bus_rdata[STAT_AVAIL_BIT] = avail;
                bus_rdata[STAT_FULL_BIT]  = fifo_full;
            end
            default: bus_rdata[7:0] = fifo_empty ? 8'h00 : fifo_dout;
        endcase
    end

    // R6: a flush drops the interrupt on the next cycle.
    a_r6_flush_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !irq);

    // R9: an empty queue reads as zero.
    a_r9_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && fifo_empty) |-> (bus_rdata == '0));

    // R5: data-available is never raised by an empty queue.
    a_r5_no_avail_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !bus_rdata[STAT_AVAIL_BIT] || bus_addr != REG_STAT);
endmodule

// File: tb/sim_irrx_uart.sv
`timescale 1ns/1ps
module sim_irrx_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        rx_in = 1'b1;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] expq[$];

    always #2.5 clk = ~clk;

    irrx_uart u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_in(rx_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Expected stored byte from the requirements (R2, R3, R4).
    function automatic logic [7:0] exp_entry(input logic [7:0] d, input logic [1:0] pm,
                                             input logic bad_par, input logic bad_stop);
        logic pen = (pm == 2'd1) || (pm == 2'd2);
        return {bad_stop, pen && bad_par, d[5:0]};
    endfunction

    // Drive one frame at 16*div clocks per bit, then two idle bits.
    task automatic send_byte(input logic [7:0] d, input logic [1:0] pm, input logic bad_par,
                             input logic bad_stop, input int div);
        int bc = 16 * ((div <= 1) ? 1 : div);
        logic p;
        rx_in = 1'b0; wait_cyc(bc);
        for (int i = 0; i < 8; i++) begin rx_in = d[i]; wait_cyc(bc); end
        if (pm == 2'd1 || pm == 2'd2) begin
            p = (pm == 2'd1) ? ~(^d) : (^d);
            rx_in = p ^ bad_par; wait_cyc(bc);
        end
        rx_in = !bad_stop; wait_cyc(bc);
        rx_in = 1'b1; wait_cyc(2 * bc);
        expq.push_back(exp_entry(d, pm, bad_par, bad_stop));
    endtask

    task automatic drain(input string req);
        logic [15:0] v;
        while (expq.size() > 0) begin
            rd(2'd3, v);
            chk(req, v, {8'h00, expq.pop_front()});
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state of all registers and irq
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset register", v, 16'h0000);
        end
        chk("R1 irq after reset", {15'd0, irq}, 16'h0000);

        // R7: flush bit reads back 0, other control fields hold
        wr(2'd0, 16'h0033);
        rd(2'd0, v);
        chk("R7 flush bit reads 0", v, 16'h0013);

        // R2 R5 R6: single byte, group of one, interrupt enabled
        wr(2'd0, 16'h0010);
        wr(2'd1, 16'h0004);
        wait_cyc(20);
        send_byte(8'hA5, 2'd0, 1'b0, 1'b0, 4);
        rd(2'd2, v);
        chk("R5 avail after one byte", v, 16'h0001);
        chk("R6 irq raised", {15'd0, irq}, 16'h0001);
        drain("R2 basic byte");
        rd(2'd2, v);
        chk("R5 avail drops after pop", v, 16'h0000);

        // R3 R4 R5 R6: random groups, parity modes, injected errors
        for (int it = 0; it < 25; it++) begin
            int div = 3 + ($urandom % 3);
            logic [1:0] pm = 2'($urandom % 4);
            int g = $urandom % 4;
            logic ie = 1'($urandom % 2);
            wr(2'd0, {11'd0, ie, 2'b00, pm});
            wr(2'd1, {8'(g), 8'(div)});
            wait_cyc(20);
            for (int k = 0; k <= g; k++) begin
                if (k == g) begin
                    rd(2'd2, v);
                    chk("R5 avail low one byte short", v, 16'h0000);
                end
                send_byte(8'($urandom), pm, ($urandom % 4) == 0, ($urandom % 4) == 0, div);
            end
            rd(2'd2, v);
            chk("R5 avail at group size", v, 16'h0001);
            chk("R6 irq follows enable", {15'd0, irq}, {15'd0, ie});
            drain("R3 R4 stored entry");
        end

        // R8: fill 16, drop the 17th, full flag
        wr(2'd0, 16'h0010);
        wr(2'd1, 16'h0F03);
        wait_cyc(20);
        for (int k = 0; k < 17; k++) begin
            if (k == 15) begin
                rd(2'd2, v);
                chk("R5 15 of 16 not available", v, 16'h0000);
            end
            send_byte(8'(k * 7 + 1), 2'd0, 1'b0, 1'b0, 3);
        end
        void'(expq.pop_back());
        rd(2'd2, v);
        chk("R8 full and available", v, 16'h0003);
        drain("R8 entries survive drop");
        rd(2'd3, v);
        chk("R9 empty read returns zero", v, 16'h0000);
        rd(2'd2, v);
        chk("R9 no underflow after empty read", v, 16'h0000);

        // R7: flush empties a partly filled queue
        wr(2'd1, 16'h0003);
        for (int k = 0; k < 3; k++) send_byte(8'h3C, 2'd0, 1'b0, 1'b0, 3);
        chk("R7 irq before flush", {15'd0, irq}, 16'h0001);
        wr(2'd0, 16'h0030);
        expq.delete();
        rd(2'd2, v);
        chk("R7 status after flush", v, 16'h0000);
        chk("R7 irq after flush", {15'd0, irq}, 16'h0000);
        rd(2'd3, v);
        chk("R7 data after flush", v, 16'h0000);

        // R2 R3: divisor 0x11 with even parity, good and bad parity
        wr(2'd0, 16'h0002);
        wr(2'd1, 16'h0111);
        wait_cyc(40);
        send_byte(8'h5B, 2'd2, 1'b0, 1'b0, 17);
        send_byte(8'h5B, 2'd2, 1'b1, 1'b0, 17);
        rd(2'd2, v);
        chk("R5 group of two ready", v, 16'h0001);
        chk("R6 irq masked", {15'd0, irq}, 16'h0000);
        drain("R2 R3 slow even parity");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule